// File: doc/BRIEF.md
# Three-Wire Serial Register Host

This block is the host end of a three-wire serial link to a radio transceiver. The link has an active-low select, a serial clock that the host drives, and one data line that both ends share. The data line is split into an output value, an output enable and an input value, so that the pad ring can build the bidirectional buffer. Local logic issues one request at a time. Each request carries a kind, an address, a write value and a burst length. The block turns each request into a complete framed transaction on the wire.

Four kinds of transaction are supported: a register write, a register read, a one-byte strobe command, and a burst read from the receive FIFO. The block always sets the read marker in bit 6 of the first byte of a read or a burst. After that byte the data line turns around to an input. Every byte of a transaction, burst bytes included, runs under a single select window. Each received byte is presented with a one-cycle valid strobe. The end of each transaction is marked by a one-cycle done pulse.

The serial clock runs from a divider: each half of a bit lasts `DIV` system clocks. The register meanings and the calibration flow of the transceiver belong to the logic that issues the requests.

Top module: `spi3w_host`

## Requirements
- R1: At reset and between transactions, select is high, the serial clock is low, the data line is an output (enable high) at level 1, and busy is low.
- R2: Select is low without a break from the cycle after a request is accepted until the end of the last half-period of the transaction, across every byte of a burst.
- R3: A bit is a low half-period followed by a high half-period, each `DIV` cycles long. Bytes leave MSB first. The output data changes only while the clock is low, so it is stable across every rising edge.
- R4: Write (kind 0) sends the address byte unchanged, then the write value, then one idle low half-period: 33 half-periods in total.
- R5: Read (kind 1) sends the address with bit 6 forced to 1. The enable then drops for one gap half-period. Eight input bits are sampled MSB first, each on the last system clock of a low half-period. One low tail half-period follows, and the enable returns high together with the release of select.
- R6: Strobe (kind 2) sends the address byte alone, unchanged, followed by one tail half-period: 17 half-periods in total.
- R7: Burst (kind 3) sends `FIFO_ADDR` with bit 6 set (0x45 by default). It then reads the requested number of bytes back to back with no gap. A length of 0 reads one byte, and lengths above `BURST_MAX` read `BURST_MAX` bytes. Each received byte raises `rd_byte_vld` for one cycle with the byte on `rd_data`.
- R8: `done` is a one-cycle pulse in the cycle `DIV` × (half-periods) after the accepting edge. `busy` is high from the cycle after acceptance up to that cycle.
- R9: A request presented while busy is ignored, and the transaction in flight continues unchanged.
- R10: `rd_data` changes only when a new byte is received. It holds across later transactions that receive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_kind | input | 2 | 0 write, 1 read, 2 strobe, 3 burst |
| req_addr | input | 8 | Address byte or strobe code |
| req_wdata | input | 8 | Value for a write |
| req_len | input | LEN_W | Burst byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Last received byte |
| rd_byte_vld | output | 1 | One-cycle pulse per received byte |
| spi_csn | output | 1 | Active-low select |
| spi_sck | output | 1 | Serial clock, idles low |
| sdio_out | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| sdio_in | input | 1 | Data line input value |

## Verification
The assertions assume that the device on the far side drives the data line only while the enable is low. They also assume that `req_kind` and `req_len` are meaningful only in the cycle in which `req_valid` is taken. The bench acts as the far-side device. It drives `sdio_in` on the falling system-clock edge, holding each bit for the whole of its serial bit, so the value is settled well before the sampling edge. Requests are presented for a single cycle, except where a request is deliberately held during a transaction to probe R9.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;

  typedef enum logic [1:0] {
    K_WRITE  = 2'd0,
    K_READ   = 2'd1,
    K_STROBE = 2'd2,
    K_BURST  = 2'd3
  } xfer_kind_t;

  localparam logic [7:0] READ_MARK = 8'h40;

  // First byte placed on the wire for a request kind.
  function automatic logic [7:0] first_byte(xfer_kind_t k, logic [7:0] addr,
                                            logic [7:0] fifo_addr);
    case (k)
      K_READ:  return addr | READ_MARK;
      K_BURST: return fifo_addr | READ_MARK;
      default: return addr;
    endcase
  endfunction

  // Number of bytes received for a request kind.
  function automatic int unsigned rx_count(xfer_kind_t k, int unsigned len,
                                           int unsigned max_len);
    if (k == K_READ)  return 1;
    if (k != K_BURST) return 0;
    if (len == 0)     return 1;
    return (len > max_len) ? max_len : len;
  endfunction

endpackage

// File: rtl/spi3w_tick.sv
`timescale 1ns/1ps
module spi3w_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  // R3
  half_period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == '0));
endmodule

// File: rtl/spi3w_shifter.sv
`timescale 1ns/1ps
module spi3w_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       active,
  input  logic       tick,
  input  logic       dir_in,
  input  logic       sdio_in,
  output logic       msb,
  output logic       slot_odd,
  output logic       byte_end,
  output logic [7:0] byte_q
);
  logic [7:0] sreg;
  logic [3:0] slot;
  logic       step;

  assign step     = active && tick;
  assign msb      = sreg[7];
  assign slot_odd = slot[0];
  assign byte_end = step && (slot == 4'd15);
  assign byte_q   = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      slot <= '0;
    end else if (load) begin
      sreg <= load_byte;
      slot <= '0;
    end else if (step) begin
      slot <= slot + 4'd1;
      if (!dir_in && slot[0])      sreg <= {sreg[6:0], 1'b0};
      else if (dir_in && !slot[0]) sreg <= {sreg[6:0], sdio_in};
    end
  end

  // R3
  shift_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(sreg) && $stable(slot)));
endmodule

// File: rtl/spi3w_ctrl.sv
`timescale 1ns/1ps
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int         BURST_MAX = 16,
  parameter int         LEN_W     = 5,
  parameter logic [7:0] FIFO_ADDR = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  xfer_kind_t       req_kind,
  input  logic [7:0]       req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  input  logic             tick,
  input  logic             byte_end,
  input  logic             slot_odd,
  input  logic             msb,
  input  logic [7:0]       byte_q,
  output logic             run,
  output logic             shift_en,
  output logic             load,
  output logic [7:0]       load_byte,
  output logic             dir_in,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             rd_byte_vld,
  output logic             spi_csn,
  output logic             spi_sck,
  output logic             sdio_out,
  output logic             sdio_oe
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_TAIL} st_t;

  st_t              st;
  xfer_kind_t       kind_q;
  logic [7:0]       wdata_q;
  logic             first_q;
  logic             dir_in_q;
  logic [LEN_W-1:0] left_q;
  logic             done_q;
  logic [7:0]       rd_q;
  logic             vld_q;
  logic             accept;
  logic             wr_second;

  assign accept    = req_valid && (st == ST_IDLE);
  assign wr_second = byte_end && first_q && (kind_q == K_WRITE);
  assign load      = accept || wr_second;
  assign load_byte = accept ? first_byte(req_kind, req_addr, FIFO_ADDR) : wdata_q;

  assign run         = (st != ST_IDLE);
  assign shift_en    = (st == ST_SHIFT);
  assign dir_in      = dir_in_q;
  assign done        = done_q;
  assign rd_data     = rd_q;
  assign rd_byte_vld = vld_q;
  assign spi_csn     = (st == ST_IDLE);
  assign spi_sck     = (st == ST_SHIFT) && slot_odd;
  assign sdio_out    = ((st == ST_SHIFT) && !dir_in_q) ? msb : 1'b1;
  assign sdio_oe     = !dir_in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind_q   <= K_WRITE;
      wdata_q  <= '0;
      first_q  <= 1'b0;
      dir_in_q <= 1'b0;
      left_q   <= '0;
      done_q   <= 1'b0;
      rd_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          st       <= ST_SHIFT;
          kind_q   <= req_kind;
          wdata_q  <= req_wdata;
          first_q  <= 1'b1;
          dir_in_q <= 1'b0;
          left_q   <= LEN_W'(rx_count(req_kind, int'(req_len), BURST_MAX));
        end
        ST_SHIFT: if (byte_end) begin
          if (first_q) begin
            first_q <= 1'b0;
            case (kind_q)
              K_WRITE:  ;
              K_STROBE: st <= ST_TAIL;
              default: begin
                st       <= ST_GAP;
                dir_in_q <= 1'b1;
              end
            endcase
          end else if (dir_in_q) begin
            rd_q   <= byte_q;
            vld_q  <= 1'b1;
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) st <= ST_TAIL;
          end else begin
            st <= ST_TAIL;
          end
        end
        ST_GAP: if (tick) st <= ST_SHIFT;
        ST_TAIL: if (tick) begin
          st       <= ST_IDLE;
          done_q   <= 1'b1;
          dir_in_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  sck_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_csn);

  // R5
  turnaround_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdio_oe |-> !spi_csn);

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(sdio_out));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && req_valid) |=> ($stable(kind_q) && $stable(wdata_q)));

  // R7
  burst_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dir_in_q) |-> (left_q != '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_byte_vld |-> $stable(rd_data));
endmodule

// File: rtl/spi3w_host.sv
`timescale 1ns/1ps
module spi3w_host
  import spi3w_pkg::*;
#(
  parameter int         DIV       = 2,
  parameter int         BURST_MAX = 16,
  parameter logic [7:0] FIFO_ADDR = 8'h05,
  parameter int         LEN_W     = $clog2(BURST_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [7:0]       req_addr,
  input  logic [7:0]       req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             rd_byte_vld,
  output logic             spi_csn,
  output logic             spi_sck,
  output logic             sdio_out,
  output logic             sdio_oe,
  input  logic             sdio_in
);
  logic       run;
  logic       tick;
  logic       shift_en;
  logic       load;
  logic [7:0] load_byte;
  logic       dir_in;
  logic       msb;
  logic       slot_odd;
  logic       byte_end;
  logic [7:0] byte_q;

  assign busy = run;

  spi3w_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spi3w_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_byte(load_byte),
    .active   (shift_en),
    .tick     (tick),
    .dir_in   (dir_in),
    .sdio_in  (sdio_in),
    .msb      (msb),
    .slot_odd (slot_odd),
    .byte_end (byte_end),
    .byte_q   (byte_q)
  );

  spi3w_ctrl #(
    .BURST_MAX(BURST_MAX),
    .LEN_W    (LEN_W),
    .FIFO_ADDR(FIFO_ADDR)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (xfer_kind_t'(req_kind)),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_len    (req_len),
    .tick       (tick),
    .byte_end   (byte_end),
    .slot_odd   (slot_odd),
    .msb        (msb),
    .byte_q     (byte_q),
    .run        (run),
    .shift_en   (shift_en),
    .load       (load),
    .load_byte  (load_byte),
    .dir_in     (dir_in),
    .done       (done),
    .rd_data    (rd_data),
    .rd_byte_vld(rd_byte_vld),
    .spi_csn    (spi_csn),
    .spi_sck    (spi_sck),
    .sdio_out   (sdio_out),
    .sdio_oe    (sdio_oe)
  );

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> (sdio_oe && sdio_out && !spi_sck));
endmodule

// File: tb/test_spi3w_host.sv
`timescale 1ns/1ps
module test_spi3w_host;
  localparam int DIV       = 2;
  localparam int BURST_MAX = 16;
  localparam int LEN_W     = $clog2(BURST_MAX + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_kind = 2'd0;
  logic [7:0]       req_addr = 8'h00;
  logic [7:0]       req_wdata = 8'h00;
  logic [LEN_W-1:0] req_len = '0;
  logic             busy, done, rd_byte_vld;
  logic [7:0]       rd_data;
  logic             spi_csn, spi_sck, sdio_out, sdio_oe;
  logic             sdio_in = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit         e_sck[$], e_oe[$], e_out[$], e_in[$];
  logic [7:0] exp_rd[$], got_rd[$];

  always #2.5 clk = ~clk;

  spi3w_host #(.DIV(DIV), .BURST_MAX(BURST_MAX)) i_spi3w_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_byte_vld(rd_byte_vld),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .sdio_in(sdio_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got=%0h exp=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic push_slot(input bit sck, input bit oe, input bit out, input bit din);
    e_sck.push_back(sck); e_oe.push_back(oe); e_out.push_back(out); e_in.push_back(din);
  endtask

  task automatic push_tx(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      push_slot(1'b0, 1'b1, b[k], 1'b0);
      push_slot(1'b1, 1'b1, b[k], 1'b0);
    end
  endtask

  task automatic push_rx(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      push_slot(1'b0, 1'b0, 1'b1, b[k]);
      push_slot(1'b1, 1'b0, 1'b1, b[k]);
    end
    exp_rd.push_back(b);
  endtask

  task automatic idle_pins(input string tag);
    check(spi_csn && !spi_sck && sdio_oe && sdio_out && !busy, "R1", tag,
          {spi_csn, spi_sck, sdio_oe, sdio_out, busy}, 5'b10110);
  endtask

  // kind: 0 write, 1 read, 2 strobe, 3 burst
  task automatic run_txn(input int kind, input logic [7:0] addr,
                         input logic [7:0] wdata, input int len,
                         input bit poke, input string lbl);
    int nrx;
    int ncyc;
    logic [7:0] first;
    e_sck.delete(); e_oe.delete(); e_out.delete(); e_in.delete();
    exp_rd.delete(); got_rd.delete();
    first = (kind == 1) ? (addr | 8'h40) : (kind == 3) ? 8'h45 : addr;
    push_tx(first);
    if (kind == 0) begin
      push_tx(wdata);
      push_slot(1'b0, 1'b1, 1'b1, 1'b0);
    end else if (kind == 2) begin
      push_slot(1'b0, 1'b1, 1'b1, 1'b0);
    end else begin
      nrx = (kind == 1) ? 1 : (len == 0) ? 1 : (len > BURST_MAX) ? BURST_MAX : len;
      push_slot(1'b0, 1'b0, 1'b1, 1'b0);
      for (int j = 0; j < nrx; j++) push_rx(8'(8'h3C + 37 * j) ^ addr ^ wdata);
      push_slot(1'b0, 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = addr;
    req_wdata = wdata; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    ncyc = e_sck.size() * DIV;
    for (int i = 0; i < ncyc; i++) begin
      int s;
      s = i / DIV;
      if (poke && i >= 3 && i < 9) begin
        req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'hFF; req_wdata = 8'h99;
      end else begin
        req_valid = 1'b0;
      end
      check(spi_csn == 1'b0, "R2", {lbl, " select"}, spi_csn, 0);
      check(spi_sck == e_sck[s], "R3", {lbl, " sck"}, spi_sck, e_sck[s]);
      check(sdio_oe == e_oe[s], "R5", {lbl, " oe"}, sdio_oe, e_oe[s]);
      if (e_oe[s]) check(sdio_out == e_out[s], "R3", {lbl, " data"}, sdio_out, e_out[s]);
      check(busy && !done, "R8", {lbl, " busy/done"}, {busy, done}, 2'b10);
      if (rd_byte_vld) got_rd.push_back(rd_data);
      sdio_in = e_in[s];
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(done == 1'b1, "R8", {lbl, " done pulse"}, done, 1);
    idle_pins({lbl, " end idle"});
    check(got_rd.size() == exp_rd.size(), "R7", {lbl, " byte count"},
          got_rd.size(), exp_rd.size());
    for (int j = 0; j < exp_rd.size() && j < got_rd.size(); j++)
      check(got_rd[j] == exp_rd[j], "R5", {lbl, " rx byte"}, got_rd[j], exp_rd[j]);
    if (exp_rd.size() > 0)
      check(rd_data == exp_rd[exp_rd.size()-1], "R10", {lbl, " rd_data"},
            rd_data, exp_rd[exp_rd.size()-1]);
    @(negedge clk);
    check(done == 1'b0, "R8", {lbl, " done low"}, done, 0);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    idle_pins("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1 after reset");
    check(!done && !rd_byte_vld && rd_data == 8'h00, "R1", "reset outputs",
          {done, rd_byte_vld, rd_data}, 0);

    run_txn(0, 8'h0F, 8'hA0, 0, 1'b0, "R4 write a");
    run_txn(0, 8'h26, 8'h3B, 0, 1'b0, "R4 write b");
    run_txn(2, 8'hA0, 8'h00, 0, 1'b0, "R6 standby");
    run_txn(2, 8'hF0, 8'h00, 0, 1'b0, "R6 fifo reset");
    run_txn(2, 8'hC0, 8'h00, 0, 1'b0, "R6 rx mode");
    run_txn(1, 8'h02, 8'h00, 0, 1'b0, "R5 read plain");
    run_txn(1, 8'h45, 8'h11, 0, 1'b0, "R5 read marked");
    held = rd_data;
    run_txn(0, 8'h0F, 8'h55, 0, 1'b0, "R10 write after read");
    check(rd_data == held, "R10", "hold after write", rd_data, held);
    run_txn(2, 8'hA0, 8'h00, 0, 1'b0, "R10 strobe after read");
    check(rd_data == held, "R10", "hold after strobe", rd_data, held);
    run_txn(3, 8'h00, 8'h00, 4, 1'b0, "R7 burst 4");
    run_txn(3, 8'h00, 8'h00, 0, 1'b0, "R7 burst len0");
    run_txn(3, 8'h00, 8'h00, BURST_MAX, 1'b0, "R7 burst max");
    run_txn(3, 8'h00, 8'h00, 20, 1'b0, "R7 burst clamp");
    run_txn(0, 8'h33, 8'hC5, 0, 1'b1, "R9 write poked");
    run_txn(1, 8'h00, 8'h00, 0, 1'b1, "R9 read poked");
    repeat (3) @(negedge clk);
    idle_pins("R1 final idle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog: got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule